// File: doc/BRIEF.md
# Three-Bank Interrupt Collector

This block gathers 24 event inputs from the functions of a power-management style device and merges them into one active-high interrupt line. The events fall into three banks of eight. Each bank has three registers: a sticky status register, a latch-enable mask, and an output-line mask. A status bit is set on a rising edge of its event input, but only when the latch mask leaves that bit enabled. The interrupt line goes high while any latched bit is not hidden by its line mask.

Software uses a byte-wide register bus. A start strobe loads an address, and each read or write strobe then moves the address on by one. This lets the three status bytes be fetched in one burst, and lets three mask bytes be written in one burst. A single write of any value to any one of the three status addresses clears all 24 status bits together. An event edge that arrives in the same cycle as that write is still kept. The top event bit is reserved and never latches.

Top module: `evt_collect_top`

## Requirements
- R1: After reset, all six mask registers hold 0xFF, all status bits are 0, `irq_out` is low and `bus_rdata` is 0.
- R2: The register map is: status bytes for events 0-7, 8-15 and 16-23 at addresses 0, 1 and 2; line masks for the same banks at 3, 4 and 5; latch masks at 6, 7 and 8. A read strobe at address a places the byte for a on `bus_rdata` at the next clock edge, and that value holds until the next read.
- R3: When `bus_start` is high, the access uses `bus_addr`. Otherwise it uses the internal pointer. After each read or write strobe the pointer becomes the accessed address plus one, modulo 16, so bursts of several bytes reach consecutive registers.
- R4: A status bit is set at the clock edge where its event input is 1 and was 0 at the previous edge, provided its latch-mask bit is 0. An input held high does not set the bit again. An edge on a bit whose latch mask is 1 leaves the status bit at 0.
- R5: A status bit, once set, stays set until a clear write, whatever happens to its input or to the masks.
- R6: `irq_out` is a register. At each clock edge it takes the OR over all 24 bits of (status AND NOT line-mask), using the values held before that edge.
- R7: A write of any data value to address 0, 1 or 2 clears all 24 status bits at that edge.
- R8: An enabled event edge in the same cycle as a clear write is latched after the clear, so the bit reads as 1 afterwards.
- R9: Status bit 23 (bank 2, bit 7) always reads 0, even when its input rises.
- R10: Addresses 9 to 15 read as 0, and writes to them change no register.
- R11: In every mask register, 1 masks and 0 enables. A read, a bit change and a write-back of a mask byte updates only that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Use `bus_addr` for this cycle's access, or load it as the pointer |
| bus_addr | input | 4 | Start address of a burst |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| evt_in | input | 24 | Event inputs, bit i belongs to bank i/8 |
| irq_out | output | 1 | Combined interrupt, active high, registered |

## Verification
The properties assume that `evt_in` and all bus inputs are synchronous to `clk` and change only between edges. They also assume that `bus_wr` and `bus_rd` are never high in the same cycle, because the model treats an access as a read or a write but not both. The stimulus drives every input on the falling edge and issues exactly one strobe per bus cycle. Event edges are produced by explicit low-to-high steps, including one timed to coincide with a clear write.

// File: rtl/evt_collect_pkg.sv
package evt_collect_pkg;
  localparam int BANKS  = 3;
  localparam int BANK_W = 8;
  localparam int ADDR_W = 4;
  localparam int EVT_W  = BANKS * BANK_W;
  // event bits that never latch
  localparam logic [EVT_W-1:0] RSVD_BITS = 24'h80_0000;
endpackage

// File: rtl/evt_addr_seq.sv
module evt_addr_seq #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_wr,
  output logic              acc_rd
);
  logic [ADDR_W-1:0] ptr;

  assign acc_addr = start ? addr : ptr;
  assign acc_wr   = wr;
  assign acc_rd   = rd;

  always_ff @(posedge clk) begin
    if (rst)
      ptr <= '0;
    else if (wr || rd)
      ptr <= acc_addr + 1'b1;
    else if (start)
      ptr <= addr;
  end
endmodule

// File: rtl/evt_bank.sv
module evt_bank #(
  parameter int          W    = 8,
  parameter logic [W-1:0] RSVD = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         clr,
  input  logic         lm_we,
  input  logic         sm_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] stat,
  output logic [W-1:0] lmask,
  output logic [W-1:0] smask
);
  logic [W-1:0] evt_q;
  logic [W-1:0] rise;
  logic [W-1:0] kept;

  assign rise = evt & ~evt_q;
  assign kept = clr ? '0 : stat;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
      stat  <= '0;
      lmask <= '1;
      smask <= '1;
    end else begin
      evt_q <= evt;
      stat  <= (kept | (rise & ~smask)) & ~RSVD;
      if (lm_we) lmask <= wdata;
      if (sm_we) smask <= wdata;
    end
  end
endmodule

// File: rtl/evt_collect_top.sv
module evt_collect_top
  import evt_collect_pkg::*;
#(
  parameter int                         N_BANK = BANKS,
  parameter int                         BW     = BANK_W,
  parameter int                         AW     = ADDR_W,
  parameter logic [N_BANK*BW-1:0]       RSVD   = RSVD_BITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_start,
  input  logic [AW-1:0]         bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [BW-1:0]         bus_wdata,
  output logic [BW-1:0]         bus_rdata,
  input  logic [N_BANK*BW-1:0]  evt_in,
  output logic                  irq_out
);
  localparam int          NEVT   = N_BANK * BW;
  localparam logic [AW-1:0] ST_END = AW'(N_BANK);

  logic [AW-1:0] acc_addr;
  logic          acc_wr;
  logic          acc_rd;
  logic          clr_all;

  logic [BW-1:0] stat_b  [N_BANK];
  logic [BW-1:0] lmask_b [N_BANK];
  logic [BW-1:0] smask_b [N_BANK];
  logic [NEVT-1:0] stat_vec;
  logic [NEVT-1:0] lmask_vec;
  logic [NEVT-1:0] smask_vec;
  logic [BW-1:0]   rd_val;

  evt_addr_seq #(.ADDR_W(AW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (bus_start),
    .addr     (bus_addr),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .acc_addr (acc_addr),
    .acc_wr   (acc_wr),
    .acc_rd   (acc_rd)
  );

  assign clr_all = acc_wr && (acc_addr < ST_END);

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    localparam logic [AW-1:0] LM_A = AW'(N_BANK + b);
    localparam logic [AW-1:0] SM_A = AW'(2 * N_BANK + b);
    evt_bank #(
      .W    (BW),
      .RSVD (RSVD[b*BW +: BW])
    ) u_bank (
      .clk   (clk),
      .rst   (rst),
      .evt   (evt_in[b*BW +: BW]),
      .clr   (clr_all),
      .lm_we (acc_wr && (acc_addr == LM_A)),
      .sm_we (acc_wr && (acc_addr == SM_A)),
      .wdata (bus_wdata),
      .stat  (stat_b[b]),
      .lmask (lmask_b[b]),
      .smask (smask_b[b])
    );
    assign stat_vec [b*BW +: BW] = stat_b[b];
    assign lmask_vec[b*BW +: BW] = lmask_b[b];
    assign smask_vec[b*BW +: BW] = smask_b[b];
  end

  always_comb begin
    rd_val = '0;
    for (int b = 0; b < N_BANK; b++) begin
      if (acc_addr == AW'(b))              rd_val = stat_b[b];
      if (acc_addr == AW'(N_BANK + b))     rd_val = lmask_b[b];
      if (acc_addr == AW'(2 * N_BANK + b)) rd_val = smask_b[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      if (acc_rd) bus_rdata <= rd_val;
      irq_out <= |(stat_vec & ~lmask_vec);
    end
  end
endmodule

// File: rtl/evt_collect_chk.sv
module evt_collect_chk #(
  parameter int              NEVT = 24,
  parameter logic [NEVT-1:0] RSVD = '0
) (
  input logic            clk,
  input logic            rst,
  input logic [NEVT-1:0] evt_in,
  input logic            clr_all,
  input logic [NEVT-1:0] stat_vec,
  input logic [NEVT-1:0] lmask_vec,
  input logic [NEVT-1:0] smask_vec,
  input logic            irq_out
);
  logic [NEVT-1:0] prev_evt;
  logic [NEVT-1:0] fresh;

  always_ff @(posedge clk) begin
    if (rst) prev_evt <= '0;
    else     prev_evt <= evt_in;
  end

  assign fresh = evt_in & ~prev_evt & ~smask_vec & ~RSVD;

  a_r1_reset_values: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq_out && stat_vec == '0 && (&lmask_vec) && (&smask_vec)));

  a_r4_masked_stays_clear: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_vec & ~$past(stat_vec) & $past(smask_vec)) == '0));

  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_all |=> ((stat_vec & $past(stat_vec)) == $past(stat_vec)));

  a_r6_irq_high: assert property (@(posedge clk) disable iff (rst)
    (|(stat_vec & ~lmask_vec)) |=> irq_out);

  a_r6_irq_low: assert property (@(posedge clk) disable iff (rst)
    !(|(stat_vec & ~lmask_vec)) |=> !irq_out);

  a_r7_clear_all: assert property (@(posedge clk) disable iff (rst)
    (clr_all && (evt_in & ~prev_evt) == '0) |=> (stat_vec == '0));

  a_r8_edge_never_lost: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_vec & $past(fresh)) == $past(fresh)));

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (stat_vec & RSVD) == '0);
endmodule

bind evt_collect_top evt_collect_chk #(
  .NEVT (NEVT),
  .RSVD (RSVD)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .evt_in    (evt_in),
  .clr_all   (clr_all),
  .stat_vec  (stat_vec),
  .lmask_vec (lmask_vec),
  .smask_vec (smask_vec),
  .irq_out   (irq_out)
);

// File: tb/test_evt_collect_top.sv
`timescale 1ns/1ps
module test_evt_collect_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        b_start = 1'b0;
  logic [3:0]  b_addr = '0;
  logic        b_wr = 1'b0;
  logic        b_rd = 1'b0;
  logic [7:0]  b_wd = '0;
  logic [7:0]  b_rdata;
  logic [23:0] ev = '0;
  logic        irq;

  int vectors = 0;
  int fails = 0;
  logic [7:0] rb [16];
  logic [7:0] saved [16];

  always #2 clk = ~clk;

  evt_collect_top i_evt_collect_top (
    .clk       (clk),
    .rst       (rst),
    .bus_start (b_start),
    .bus_addr  (b_addr),
    .bus_wr    (b_wr),
    .bus_rd    (b_rd),
    .bus_wdata (b_wd),
    .bus_rdata (b_rdata),
    .evt_in    (ev),
    .irq_out   (irq)
  );

  // behavioural reference model
  logic [23:0] m_st, m_lm, m_sm, m_evq;
  logic        m_irq;
  logic [7:0]  m_rdata;
  logic [3:0]  m_ptr;

  function automatic logic [7:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return m_st[7:0];
      4'd1: return m_st[15:8];
      4'd2: return m_st[23:16];
      4'd3: return m_lm[7:0];
      4'd4: return m_lm[15:8];
      4'd5: return m_lm[23:16];
      4'd6: return m_sm[7:0];
      4'd7: return m_sm[15:8];
      4'd8: return m_sm[23:16];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [3:0]  eff;
    logic [23:0] rise, st;
    logic        n_irq;
    if (rst) begin
      m_st = '0; m_lm = '1; m_sm = '1; m_evq = '0;
      m_irq = 1'b0; m_rdata = '0; m_ptr = '0;
    end else begin
      eff   = b_start ? b_addr : m_ptr;
      rise  = ev & ~m_evq;
      n_irq = |(m_st & ~m_lm);
      if (b_rd) m_rdata = m_read(eff);
      st = m_st;
      if (b_wr && eff <= 4'd2) st = '0;
      st = st | (rise & ~m_sm);
      st[23] = 1'b0;
      if (b_wr && eff >= 4'd3 && eff <= 4'd5) m_lm[(eff-4'd3)*8 +: 8] = b_wd;
      if (b_wr && eff >= 4'd6 && eff <= 4'd8) m_sm[(eff-4'd6)*8 +: 8] = b_wd;
      m_st = st; m_evq = ev; m_irq = n_irq;
      if (b_wr || b_rd) m_ptr = eff + 4'd1;
      else if (b_start) m_ptr = b_addr;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (!rst) begin
      chk("R2", "rdata vs model", {24'h0, b_rdata}, {24'h0, m_rdata});
      chk("R6", "irq vs model", {31'h0, irq}, {31'h0, m_irq});
    end
  endtask

  task automatic idle(input int n);
    b_start = 0; b_wr = 0; b_rd = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr_burst(input logic [3:0] a, input int n,
                          input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    for (int k = 0; k < n; k++) begin
      b_start = (k == 0); b_addr = a; b_wr = 1; b_rd = 0;
      b_wd = (k == 0) ? d0 : (k == 1) ? d1 : d2;
      step();
    end
    idle(1);
  endtask

  task automatic rd_burst(input logic [3:0] a, input int n);
    for (int k = 0; k < n; k++) begin
      b_start = (k == 0); b_addr = a; b_rd = 1; b_wr = 0;
      step();
      rb[k] = b_rdata;
    end
    idle(1);
  endtask

  task automatic pulse(input logic [23:0] m);
    ev = m; step();
    ev = '0; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    step();
    // R1: reset values
    chk("R1", "irq after reset", {31'h0, irq}, 32'h0);
    chk("R1", "rdata after reset", {24'h0, b_rdata}, 32'h0);
    rd_burst(4'd0, 9);
    for (int k = 0; k < 9; k++)
      chk("R1", "reset register byte", {24'h0, rb[k]}, (k < 3) ? 32'h00 : 32'hFF);

    // R3: burst write with auto-increment, R2 map readback
    wr_burst(4'd3, 3, 8'h5A, 8'h3C, 8'h81);
    rd_burst(4'd3, 3);
    chk("R3", "line mask bank0", {24'h0, rb[0]}, 32'h5A);
    chk("R3", "line mask bank1", {24'h0, rb[1]}, 32'h3C);
    chk("R3", "line mask bank2", {24'h0, rb[2]}, 32'h81);
    wr_burst(4'd3, 3, 8'h00, 8'h00, 8'h00);
    wr_burst(4'd6, 3, 8'h00, 8'h00, 8'h00);
    rd_burst(4'd6, 3);
    chk("R2", "latch masks cleared", {8'h0, rb[2], rb[1], rb[0]}, 32'h0);

    // R4: edge latch, R6 irq
    pulse(24'h000001);
    rd_burst(4'd0, 3);
    chk("R4", "status after pulse on bit0", {8'h0, rb[2], rb[1], rb[0]}, 32'h000001);
    chk("R6", "irq with unmasked status", {31'h0, irq}, 32'h1);

    // R4 held level, R7 clear by write to address 1 with arbitrary data
    ev = 24'h000200; idle(3);
    rd_burst(4'd0, 3);
    chk("R4", "status with held bit9", {8'h0, rb[2], rb[1], rb[0]}, 32'h000201);
    wr_burst(4'd1, 1, 8'hAB, 8'h00, 8'h00);
    idle(2);
    rd_burst(4'd0, 3);
    chk("R7", "status after clear (held level no relatch)", {8'h0, rb[2], rb[1], rb[0]}, 32'h0);
    chk("R7", "irq after clear", {31'h0, irq}, 32'h0);
    ev = '0; idle(1);

    // R11 latch mask: bit1 masked
    wr_burst(4'd6, 1, 8'h02, 8'h00, 8'h00);
    pulse(24'h000002);
    rd_burst(4'd0, 1);
    chk("R11", "masked edge not latched", {24'h0, rb[0]}, 32'h00);
    pulse(24'h000001);
    rd_burst(4'd0, 1);
    chk("R4", "enabled edge latched", {24'h0, rb[0]}, 32'h01);

    // R11 line mask hides irq, R5 status sticky through mask writes
    wr_burst(4'd3, 1, 8'h01, 8'h00, 8'h00);
    idle(2);
    chk("R11", "line mask drops irq", {31'h0, irq}, 32'h0);
    rd_burst(4'd0, 1);
    chk("R5", "status kept while masked", {24'h0, rb[0]}, 32'h01);
    rd_burst(4'd3, 1);
    wr_burst(4'd3, 1, rb[0] & ~8'h01, 8'h00, 8'h00);
    idle(2);
    chk("R11", "read-modify-write unmask restores irq", {31'h0, irq}, 32'h1);

    // R9 reserved bit
    wr_burst(4'd0, 1, 8'h00, 8'h00, 8'h00);
    wr_burst(4'd6, 1, 8'h00, 8'h00, 8'h00);
    pulse(24'hFFFFFF);
    rd_burst(4'd0, 3);
    chk("R9", "all events, bit23 stays 0", {8'h0, rb[2], rb[1], rb[0]}, 32'h7FFFFF);

    // R8 clear and edge in the same cycle
    ev = '0; idle(1);
    b_start = 1; b_addr = 4'd2; b_wr = 1; b_wd = 8'h55; ev = 24'h000010;
    step();
    ev = '0; idle(2);
    rd_burst(4'd0, 3);
    chk("R8", "edge during clear kept", {8'h0, rb[2], rb[1], rb[0]}, 32'h000010);

    // R10 unmapped addresses
    rd_burst(4'd0, 9);
    for (int k = 0; k < 9; k++) saved[k] = rb[k];
    wr_burst(4'd9, 3, 8'hFF, 8'hFF, 8'hFF);
    wr_burst(4'd12, 3, 8'hFF, 8'hFF, 8'hFF);
    wr_burst(4'd15, 1, 8'hFF, 8'hFF, 8'hFF);
    rd_burst(4'd9, 7);
    for (int k = 0; k < 7; k++)
      chk("R10", "unmapped reads zero", {24'h0, rb[k]}, 32'h0);
    rd_burst(4'd0, 9);
    for (int k = 0; k < 9; k++)
      chk("R10", "mapped unchanged by unmapped writes", {24'h0, rb[k]}, {24'h0, saved[k]});

    // R3 pointer wrap 15 -> 0
    rd_burst(4'd15, 2);
    chk("R3", "pointer wraps to status bank0", {24'h0, rb[1]}, {24'h0, saved[0]});

    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule